// File: doc/BRIEF.md
# Instruction bundle packer

The packer takes a valid/ready stream of decoded instructions and emits a valid/ready stream of 128-bit bundles. Each instruction carries a 41-bit encoding, a 2-bit execution-unit class and a flag marking the end of its independent group. A bundle has three 41-bit slots and a 5-bit template. The template names the unit class of every slot and where group-ending stops fall. The packer buffers up to three pending instructions in arrival order. For every legal template it works out how many leading pending instructions fit, fills the unused slots with class-matched no-ops, and offers the bundle from the best template. Instructions it cannot place stay buffered for the next bundle, so a group may span bundles.

A flush request drains the buffer. The most recent pending instruction gets a stop, and bundles are offered until the buffer is empty. The controller is a three-state machine:
- ST_COLLECT accepts input.
- ST_OFFER presents a bundle built from a full buffer.
- ST_DRAIN presents bundles after a flush.

The transitions are:
- collect→offer when the buffer reaches three entries.
- collect→drain on a flush while something is pending.
- offer→collect when the bundle is taken.
- drain→drain when a bundle is taken and entries remain.
- drain→collect when the last entry leaves.

Top module: `bundle_packer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Slot 0 occupies bits [45:5], slot 1 occupies [86:46] and slot 2 occupies [127:87]. The template occupies [4:0]. Real instructions appear in arrival order and lower slots come first.
- R3: Class codes are mem=0, int=1, fp=2, branch=3. The legal templates are:
  - 0x00–0x03: mem,int,int
  - 0x08–0x0B: mem,mem,int
  - 0x0C/0x0D: mem,fp,int
  - 0x0E/0x0F: mem,mem,fp
  - 0x10/0x11: mem,int,branch
  - 0x12/0x13: mem,branch,branch
  - 0x16/0x17: branch,branch,branch
  - 0x18/0x19: mem,mem,branch
  - 0x1C/0x1D: mem,fp,branch
  
  An odd code adds a stop after slot 2. Codes 0x02/0x03 add a stop after slot 1, and 0x0A/0x0B add a stop after slot 0. For example, mem,mem,fp with no stops gives 0x0E, and mem(stop),mem,int(stop) gives 0x0B.
- R4: A slot holding no real instruction carries the no-op of that slot's class. The no-op is the class code in bits [40:39] and the value 1 in bits [38:0].
- R5: A template stop follows a slot exactly when that slot holds a real instruction whose stop flag is set. A template that would put a stop after a no-op is not used.
- R6: The bundle uses the template that places the most pending instructions. On a tie the lowest code wins. Placement is greedy: each slot takes the next pending instruction if class and stop agree, otherwise a no-op.
- R7: When a third instruction is accepted, a bundle is offered from the next cycle. `in_ready` is 0 while a bundle is offered, and input is accepted only when `in_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the bundle stays unchanged on the next cycle.
- R9: A flush in a cycle with `in_ready` high, with at least one pending instruction (counting one accepted that cycle), does two things. It sets the stop flag of the newest pending instruction, and it offers bundles until the buffer is empty, with no input taken meanwhile.
- R10: A flush with nothing pending and no instruction accepted has no effect. On the next cycle `in_ready` stays 1 and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_cls | input | 2 | Unit class of the instruction |
| in_stop | input | 1 | Instruction ends its group |
| in_word | input | SLOT_W | Instruction encoding |
| flush | input | 1 | Drain request |
| out_valid | output | 1 | Bundle offered |
| out_ready | input | 1 | Bundle taken |
| out_bundle | output | 5+3*SLOT_W | Template and three slots |

## Verification
A flush can arrive in the same cycle that an instruction is accepted. The forced stop must then land on that incoming instruction rather than on an older one, and a drain must start even though the buffer was empty before the edge. The bench provokes this directly with a lone branch instruction plus flush, expecting template 0x11 with the branch in slot 2. It also mixes flushes randomly into a stream with back-pressure. A behavioural model, which tracks the pending queue and state, judges every cycle's `in_ready`, `out_valid` and full bundle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int TMPL_W  = 5;
    localparam int N_SLOTS = 3;
    localparam int CLS_W   = 2;
    localparam int N_TMPL  = 22;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_OFFER   = 2'd1,
        ST_DRAIN   = 2'd2
    } pk_state_t;

    localparam logic [1:0] UC_MEM = 2'd0;
    localparam logic [1:0] UC_INT = 2'd1;
    localparam logic [1:0] UC_FP  = 2'd2;
    localparam logic [1:0] UC_BR  = 2'd3;

    // Legal template codes in search priority order (ascending).
    function automatic logic [TMPL_W-1:0] tmpl_code(input int idx);
        logic [TMPL_W-1:0] c;
        case (idx)
            0:  c = 5'h00;  1:  c = 5'h01;  2:  c = 5'h02;  3:  c = 5'h03;
            4:  c = 5'h08;  5:  c = 5'h09;  6:  c = 5'h0A;  7:  c = 5'h0B;
            8:  c = 5'h0C;  9:  c = 5'h0D;  10: c = 5'h0E;  11: c = 5'h0F;
            12: c = 5'h10;  13: c = 5'h11;  14: c = 5'h12;  15: c = 5'h13;
            16: c = 5'h16;  17: c = 5'h17;  18: c = 5'h18;  19: c = 5'h19;
            20: c = 5'h1C;  default: c = 5'h1D;
        endcase
        return c;
    endfunction

    // Slot classes packed {slot2, slot1, slot0}.
    function automatic logic [3*CLS_W-1:0] tmpl_types(input logic [TMPL_W-1:0] code);
        logic [3*CLS_W-1:0] t;
        case (code[4:1])
            4'h0, 4'h1: t = {UC_INT, UC_INT, UC_MEM};
            4'h4, 4'h5: t = {UC_INT, UC_MEM, UC_MEM};
            4'h6:       t = {UC_INT, UC_FP,  UC_MEM};
            4'h7:       t = {UC_FP,  UC_MEM, UC_MEM};
            4'h8:       t = {UC_BR,  UC_INT, UC_MEM};
            4'h9:       t = {UC_BR,  UC_BR,  UC_MEM};
            4'hB:       t = {UC_BR,  UC_BR,  UC_BR};
            4'hC:       t = {UC_BR,  UC_MEM, UC_MEM};
            default:    t = {UC_BR,  UC_FP,  UC_MEM};
        endcase
        return t;
    endfunction

    // Bit j set: a stop follows slot j.
    function automatic logic [2:0] tmpl_stops(input logic [TMPL_W-1:0] code);
        return {code[0], (code[4:1] == 4'h1), (code[4:1] == 4'h5)};
    endfunction

endpackage

// File: rtl/bp_fit.sv
module bp_fit
    import bp_pkg::*;
#(
    parameter int          SLOT_W = 41,
    parameter logic [4:0]  CODE   = 5'h00
) (
    input  logic [1:0]                    npend,
    input  logic [CLS_W*N_SLOTS-1:0]      pend_cls,
    input  logic [N_SLOTS-1:0]            pend_stp,
    input  logic [SLOT_W*N_SLOTS-1:0]     pend_word,
    output logic                          fit_ok,
    output logic [1:0]                    fit_n,
    output logic [TMPL_W+N_SLOTS*SLOT_W-1:0] fit_bundle
);

    localparam logic [3*CLS_W-1:0] TYPES = tmpl_types(CODE);
    localparam logic [2:0]         STOPS = tmpl_stops(CODE);

    // Greedy in-order placement: a slot takes the next pending
    // instruction when class and stop agree, else a class no-op.
    always_comb begin
        int         p;
        logic       bad;
        logic [1:0] tc;
        p   = 0;
        bad = 1'b0;
        fit_bundle = '0;
        fit_bundle[TMPL_W-1:0] = CODE;
        for (int j = 0; j < N_SLOTS; j++) begin
            tc = TYPES[CLS_W*j +: CLS_W];
            if (p < int'(npend) && pend_cls[CLS_W*p +: CLS_W] == tc
                && pend_stp[p] == STOPS[j]) begin
                fit_bundle[TMPL_W+SLOT_W*j +: SLOT_W] = pend_word[SLOT_W*p +: SLOT_W];
                p = p + 1;
            end else begin
                fit_bundle[TMPL_W+SLOT_W*j +: SLOT_W] = {tc, {(SLOT_W-3){1'b0}}, 1'b1};
                if (STOPS[j]) bad = 1'b1;
            end
        end
        fit_n  = 2'(p);
        fit_ok = !bad && (p != 0);
    end

endmodule

// File: rtl/bp_pick.sv
module bp_pick
    import bp_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int NT     = 22
) (
    input  logic [NT-1:0]                           cand_ok,
    input  logic [2*NT-1:0]                         cand_n,
    input  logic [NT*(TMPL_W+N_SLOTS*SLOT_W)-1:0]   cand_bundle,
    output logic [1:0]                              best_n,
    output logic [TMPL_W+N_SLOTS*SLOT_W-1:0]        best_bundle
);

    localparam int BW = TMPL_W + N_SLOTS * SLOT_W;

    // Strict comparison keeps the earliest template on a tie.
    always_comb begin
        best_n      = '0;
        best_bundle = cand_bundle[0 +: BW];
        for (int i = 0; i < NT; i++) begin
            if (cand_ok[i] && cand_n[2*i +: 2] > best_n) begin
                best_n      = cand_n[2*i +: 2];
                best_bundle = cand_bundle[BW*i +: BW];
            end
        end
    end

endmodule

// File: rtl/bundle_packer.sv
module bundle_packer
    import bp_pkg::*;
#(
    parameter int SLOT_W = 41,
    localparam int BW    = TMPL_W + N_SLOTS * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_cls,
    input  logic              in_stop,
    input  logic [SLOT_W-1:0] in_word,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BW-1:0]     out_bundle
);

    pk_state_t state_q, state_d;

    logic [1:0]        q_cls  [N_SLOTS];
    logic              q_stp  [N_SLOTS];
    logic [SLOT_W-1:0] q_word [N_SLOTS];
    logic [1:0]        cnt_q;

    logic [1:0]        n_cls  [N_SLOTS];
    logic              n_stp  [N_SLOTS];
    logic [SLOT_W-1:0] n_word [N_SLOTS];
    logic [1:0]        n_cnt;

    logic [CLS_W*N_SLOTS-1:0]  flat_cls;
    logic [N_SLOTS-1:0]        flat_stp;
    logic [SLOT_W*N_SLOTS-1:0] flat_word;

    logic [N_TMPL-1:0]    cand_ok;
    logic [2*N_TMPL-1:0]  cand_n;
    logic [N_TMPL*BW-1:0] cand_bundle;
    logic [1:0]           best_n;
    logic [BW-1:0]        best_bundle;

    logic take, acc, fl;
    logic [1:0] acc_cnt;

    always_comb begin
        for (int j = 0; j < N_SLOTS; j++) begin
            flat_cls[CLS_W*j +: CLS_W]   = q_cls[j];
            flat_stp[j]                  = q_stp[j];
            flat_word[SLOT_W*j +: SLOT_W] = q_word[j];
        end
    end

    for (genvar g = 0; g < N_TMPL; g++) begin : g_tmpl
        bp_fit #(.SLOT_W(SLOT_W), .CODE(tmpl_code(g))) u_fit (
            .npend     (cnt_q),
            .pend_cls  (flat_cls),
            .pend_stp  (flat_stp),
            .pend_word (flat_word),
            .fit_ok    (cand_ok[g]),
            .fit_n     (cand_n[2*g +: 2]),
            .fit_bundle(cand_bundle[BW*g +: BW])
        );
    end

    bp_pick #(.SLOT_W(SLOT_W), .NT(N_TMPL)) u_pick (
        .cand_ok    (cand_ok),
        .cand_n     (cand_n),
        .cand_bundle(cand_bundle),
        .best_n     (best_n),
        .best_bundle(best_bundle)
    );

    // Output process
    always_comb begin
        in_ready   = (state_q == ST_COLLECT);
        out_valid  = (state_q != ST_COLLECT);
        out_bundle = best_bundle;
    end

    assign take    = out_valid && out_ready;
    assign acc     = in_ready && in_valid;
    assign fl      = in_ready && flush;
    assign acc_cnt = cnt_q + {1'b0, acc};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (fl && acc_cnt != 2'd0)  state_d = ST_DRAIN;
                else if (acc_cnt == 2'd3)   state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (take) state_d = ST_COLLECT;
            end
            ST_DRAIN: begin
                if (take && best_n == cnt_q) state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // Pending buffer: pop on take, push on accept, mark newest on flush.
    always_comb begin
        n_cls  = q_cls;
        n_stp  = q_stp;
        n_word = q_word;
        n_cnt  = cnt_q;
        if (take) begin
            for (int j = 0; j < N_SLOTS; j++) begin
                if (j + int'(best_n) < N_SLOTS) begin
                    n_cls[j]  = q_cls[j + int'(best_n)];
                    n_stp[j]  = q_stp[j + int'(best_n)];
                    n_word[j] = q_word[j + int'(best_n)];
                end
            end
            n_cnt = cnt_q - best_n;
        end
        if (acc) begin
            n_cls[cnt_q]  = in_cls;
            n_stp[cnt_q]  = in_stop;
            n_word[cnt_q] = in_word;
            n_cnt         = cnt_q + 2'd1;
        end
        if (fl && n_cnt != 2'd0) n_stp[n_cnt - 2'd1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int j = 0; j < N_SLOTS; j++) begin
                q_cls[j]  <= '0;
                q_stp[j]  <= 1'b0;
                q_word[j] <= '0;
            end
        end else begin
            cnt_q  <= n_cnt;
            q_cls  <= n_cls;
            q_stp  <= n_stp;
            q_word <= n_word;
        end
    end

    AST_HOLD_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bundle))); // R8

    AST_FULL_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 2'd3) |-> out_valid); // R7

    AST_PICK_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (best_n != 2'd0 && best_n <= cnt_q)); // R6

    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && flush && (cnt_q != 2'd0 || in_valid)) |=> (out_valid && !in_ready)); // R9

    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && take && best_n == cnt_q) |=> in_ready); // R9

    AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && flush && !in_valid && cnt_q == 2'd0) |=> (in_ready && !out_valid)); // R10

endmodule

// File: tb/sim_bundle_packer.sv
module sim_bundle_packer;

    localparam int SW = 41;
    localparam int BW = 5 + 3 * SW;
    localparam logic [1:0] CM = 2'd0, CI = 2'd1, CF = 2'd2, CB = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_stop = 1'b0, flush = 1'b0, out_ready = 1'b0;
    logic [1:0] in_cls = '0;
    logic [SW-1:0] in_word = '0;
    logic in_ready, out_valid;
    logic [BW-1:0] out_bundle;

    always #2.5 clk = ~clk;

    bundle_packer #(.SLOT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_stop(in_stop), .in_word(in_word), .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready), .out_bundle(out_bundle)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Behavioural reference
    int            mstate = 0;  // 0 collecting, 1 offering, 2 draining
    int            mq_cls[$];
    bit            mq_stp[$];
    logic [SW-1:0] mq_word[$];

    logic [4:0] tcode [22] = '{5'h00,5'h01,5'h02,5'h03,5'h08,5'h09,5'h0A,5'h0B,5'h0C,5'h0D,
                              5'h0E,5'h0F,5'h10,5'h11,5'h12,5'h13,5'h16,5'h17,5'h18,5'h19,
                              5'h1C,5'h1D};
    string ttype [22] = '{"MII","MII","MII","MII","MMI","MMI","MMI","MMI","MFI","MFI",
                          "MMF","MMF","MIB","MIB","MBB","MBB","BBB","BBB","MMB","MMB",
                          "MFB","MFB"};
    bit [2:0] tstop [22] = '{3'b000,3'b100,3'b010,3'b110,3'b000,3'b100,3'b001,3'b101,
                             3'b000,3'b100,3'b000,3'b100,3'b000,3'b100,3'b000,3'b100,
                             3'b000,3'b100,3'b000,3'b100,3'b000,3'b100};

    logic          obs_ready, obs_valid;
    logic [BW-1:0] obs_bundle;

    function automatic int letter_cls(byte ch);
        case (ch)
            "M": return 0;
            "I": return 1;
            "F": return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [SW-1:0] nop_of(int c);
        return {2'(c), 39'd1};
    endfunction

    function automatic int try_tmpl(int ti, output logic [BW-1:0] b);
        int p = 0;
        bit bad = 0;
        b = '0;
        b[4:0] = tcode[ti];
        for (int j = 0; j < 3; j++) begin
            int c = letter_cls(ttype[ti][j]);
            bit s = tstop[ti][j];
            if (p < mq_cls.size() && mq_cls[p] == c && mq_stp[p] == s) begin
                b[5 + SW*j +: SW] = mq_word[p];
                p++;
            end else begin
                b[5 + SW*j +: SW] = nop_of(c);
                if (s) bad = 1;
            end
        end
        return bad ? 0 : p;
    endfunction

    task automatic best(output int bn, output logic [BW-1:0] bb);
        logic [BW-1:0] b;
        bn = 0;
        bb = '0;
        for (int ti = 0; ti < 22; ti++) begin
            int n = try_tmpl(ti, b);
            if (n > bn) begin bn = n; bb = b; end
        end
    endtask

    task automatic check(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [1:0] c, bit s, logic [SW-1:0] w, bit fl, bit rdy);
        int bn;
        logic [BW-1:0] bb;
        bit exp_ir, exp_ov;
        @(negedge clk);
        exp_ir = (mstate == 0);
        exp_ov = (mstate != 0);
        best(bn, bb);
        obs_ready  = in_ready;
        obs_valid  = out_valid;
        obs_bundle = out_bundle;
        check(in_ready == exp_ir, "R7 in_ready", BW'(in_ready), BW'(exp_ir));
        check(out_valid == exp_ov, "R7 out_valid", BW'(out_valid), BW'(exp_ov));
        if (exp_ov) begin
            check(out_bundle[4:0] == bb[4:0], "R6 template choice", BW'(out_bundle[4:0]), BW'(bb[4:0]));
            check(out_bundle == bb, "R2 bundle contents", out_bundle, bb);
        end
        in_valid = v; in_cls = c; in_stop = s; in_word = w; flush = fl; out_ready = rdy;
        if (exp_ov && rdy) begin
            repeat (bn) begin
                void'(mq_cls.pop_front());
                void'(mq_stp.pop_front());
                void'(mq_word.pop_front());
            end
        end
        if (exp_ir && v) begin
            mq_cls.push_back(int'(c));
            mq_stp.push_back(s);
            mq_word.push_back(w);
        end
        if (exp_ir && fl && mq_stp.size() > 0) mq_stp[mq_stp.size() - 1] = 1'b1;
        if (mstate == 0) begin
            if (fl && mq_cls.size() > 0) mstate = 2;
            else if (mq_cls.size() == 3) mstate = 1;
        end else if (mstate == 1) begin
            if (rdy) mstate = 0;
        end else begin
            if (rdy && mq_cls.size() == 0) mstate = 0;
        end
    endtask

    task automatic idle(bit rdy);
        step(0, CM, 0, '0, 0, rdy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(1);
        check(obs_ready == 1'b1, "R1 in_ready after reset", BW'(obs_ready), BW'(1));
        check(obs_valid == 1'b0, "R1 out_valid after reset", BW'(obs_valid), BW'(0));

        // R3/R2: mem,mem,fp without stops
        step(1, CM, 0, 41'h0AAAA, 0, 1);
        step(1, CM, 0, 41'h0BBBB, 0, 1);
        step(1, CF, 0, 41'h0CCCC, 0, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h0E, "R3 mmf template", BW'(obs_bundle[4:0]), BW'(5'h0E));
        check(obs_bundle[45:5] == 41'h0AAAA && obs_bundle[86:46] == 41'h0BBBB
              && obs_bundle[127:87] == 41'h0CCCC, "R2 slot order", obs_bundle, obs_bundle);

        // R5: stop after last fp slot
        step(1, CM, 0, 41'h1, 0, 1);
        step(1, CM, 0, 41'h2, 0, 1);
        step(1, CF, 1, 41'h3, 0, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h0F, "R5 end stop template", BW'(obs_bundle[4:0]), BW'(5'h0F));

        // R5/R3: mem(stop), mem, int(stop)
        step(1, CM, 1, 41'h11, 0, 1);
        step(1, CM, 0, 41'h12, 0, 1);
        step(1, CI, 1, 41'h13, 0, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h0B, "R5 mid stop template", BW'(obs_bundle[4:0]), BW'(5'h0B));

        // R4/R6: three ints, first slot gets a mem no-op
        step(1, CI, 0, 41'h21, 0, 1);
        step(1, CI, 0, 41'h22, 0, 1);
        step(1, CI, 0, 41'h23, 0, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h00, "R6 int-int choice", BW'(obs_bundle[4:0]), BW'(5'h00));
        check(obs_bundle[45:5] == {2'd0, 39'd1}, "R4 mem no-op", BW'(obs_bundle[45:5]), BW'({2'd0, 39'd1}));
        // R9: flush leftover int
        step(0, CM, 0, '0, 1, 1);
        idle(1);
        check(obs_valid == 1'b1 && obs_bundle[4:0] == 5'h01, "R9 drain leftover", BW'(obs_bundle[4:0]), BW'(5'h01));
        idle(1);

        // R9/R4: lone mem flushed
        step(1, CM, 0, 41'h31, 0, 1);
        step(0, CM, 0, '0, 1, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h0A, "R9 flushed mem template", BW'(obs_bundle[4:0]), BW'(5'h0A));
        check(obs_bundle[127:87] == {2'd1, 39'd1}, "R4 int no-op", BW'(obs_bundle[127:87]), BW'({2'd1, 39'd1}));
        idle(1);

        // R10: flush with nothing pending
        step(0, CM, 0, '0, 1, 1);
        idle(1);
        check(obs_ready == 1'b1 && obs_valid == 1'b0, "R10 empty flush", BW'({obs_ready, obs_valid}), BW'(2'b10));

        // R9: accept and flush in the same cycle
        step(1, CB, 0, 41'h41, 1, 1);
        idle(1);
        check(obs_bundle[4:0] == 5'h11 && obs_bundle[127:87] == 41'h41,
              "R9 same-cycle flush", obs_bundle, BW'(5'h11));
        idle(1);

        // R8: back-pressure hold
        step(1, CB, 0, 41'h51, 0, 0);
        step(1, CB, 0, 41'h52, 0, 0);
        step(1, CB, 1, 41'h53, 0, 0);
        repeat (5) idle(0);
        idle(1);
        check(obs_bundle[4:0] == 5'h17, "R8 held bbb bundle", BW'(obs_bundle[4:0]), BW'(5'h17));

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 9) < 7, 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
                 SW'({$urandom(), $urandom()}), $urandom_range(0, 29) == 0, $urandom_range(0, 9) < 7);
        end
        for (int i = 0; i < 10; i++) step(0, CM, 0, '0, 1, 1);
        idle(1);
        check(obs_ready == 1'b1 && obs_valid == 1'b0, "R9 final drain", BW'({obs_ready, obs_valid}), BW'(2'b10));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule